// File: doc/BRIEF.md
# Conditional-Skip Operate Evaluator

This block handles the skip-class operate instructions of a 12-bit accumulator machine. Each valid cycle it takes an instruction word, the accumulator, the link bit and the already advanced program counter (a 3-bit field and a 12-bit offset). It decides whether the next instruction is skipped, optionally clears the accumulator, raises a halt request and flags the unsupported switch-register sub-operation. The results appear one clock later from a register stage.

The skip class is picked out by instruction bits 11..9 = 7, bit 8 = 1 and bit 0 = 0. Bit 3 selects the sense. When bit 3 is 0, the instruction skips if any enabled test holds. When bit 3 is 1, it skips only if none of the enabled tests holds. Three tests exist: bit 6 tests accumulator bit 11 set, bit 5 tests accumulator equal to zero, and bit 4 tests link set. Bit 7 clears the accumulator, bit 2 is the unsupported switch-OR, and bit 1 requests halt. Any word outside the class is reported on `not_mine_o` and passes through unchanged.

Top module: `skp_opr2_eval`

## Requirements
- R1: A word belongs to the block when bits 11..9 are 7, bit 8 is 1 and bit 0 is 0. For any other valid word, `not_mine_o` is 1, `skip_o`, `halt_o` and `err_o` are 0, and the PC and accumulator outputs equal their inputs.
- R2: With bit 3 = 0 the word skips when at least one enabled test is true: bit 6 with accumulator bit 11 = 1, bit 5 with accumulator = 0, bit 4 with link = 1. With no test bit set it does not skip.
- R3: With bit 3 = 1 the word skips unless at least one enabled test is true. The tests are the same as in R2. With no test bit set it always skips.
- R4: Bit 7 drives the accumulator output to 0. All tests use the accumulator value presented with the word, before the clear. Without bit 7 the accumulator passes unchanged.
- R5: A skip gives a PC offset output equal to the input offset plus 1, modulo 4096. The field output always equals the field input. Without a skip the offset passes unchanged.
- R6: Bit 1 of a word in the class raises `halt_o` for that result. Skip and clear evaluation proceed as usual.
- R7: Bit 2 of a word in the class raises `err_o`. That result then has no skip, no halt and no clear: the PC and accumulator outputs equal their inputs.
- R8: Every output is registered. A result appears on the clock after its word is presented with `valid_i` = 1, with `valid_o` = 1. After reset, and on cycles following `valid_i` = 0, `valid_o`, `skip_o`, `halt_o`, `err_o` and `not_mine_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Instruction word and state are valid |
| instr_i | input | 12 | Instruction word |
| acc_i | input | 12 | Accumulator before execution |
| link_i | input | 1 | Link bit |
| pc_field_i | input | 3 | Field of the advanced PC |
| pc_off_i | input | 12 | Offset of the advanced PC |
| valid_o | output | 1 | Result valid |
| skip_o | output | 1 | Skip taken |
| pc_field_o | output | 3 | Resulting PC field |
| pc_off_o | output | 12 | Resulting PC offset |
| acc_o | output | 12 | Resulting accumulator |
| halt_o | output | 1 | Halt request |
| err_o | output | 1 | Unsupported switch-OR sub-operation |
| not_mine_o | output | 1 | Word is outside the skip class |

## Verification
Two functions can act on the same word: the accumulator clear and the skip tests. A word that clears the accumulator also reads it for its tests, and the offset increment can land in the same cycle as a wrap of the offset. The bench provokes the first case with clear-plus-zero-test and clear-plus-nonzero-test words on zero and nonzero accumulators. It accepts a result only when the cleared accumulator output comes with the skip decision that the pre-clear value implies. The second case is provoked by a skipping word with offset 7777 octal. It is judged by a 0000 offset with an unchanged field.

// File: rtl/skp_pkg.sv
// Package: shared types for the skip-class operate evaluator.
// Assumes a 12-bit instruction format with fixed bit positions.
package skp_pkg;
    // Decoded control fields of one instruction word
    typedef struct packed {
        logic mine;       // word is in the skip class
        logic sense_inv;  // inverted (AND-of-negations) sense
        logic t_sign;     // test accumulator sign bit
        logic t_zero;     // test accumulator equal to zero
        logic t_link;     // test link
        logic clr;        // clear accumulator
        logic osr;        // unsupported switch-OR
        logic hlt;        // halt request
    } skp_ctl_t;
endpackage

// File: rtl/skp_decode.sv
// Module: skp_decode
// Splits an instruction word into skip-class control fields.
// Assumes the 12-bit word layout; bit positions are fixed by the format.
module skp_decode
    import skp_pkg::*;
#(
    parameter int WORD_W = 12
) (
    input  logic [WORD_W-1:0] word_i,
    output skp_ctl_t          ctl_o
);
    localparam int OPC_LSB = WORD_W - 3;
    localparam int GRP_BIT = WORD_W - 4;
    localparam logic [2:0] OPC_OPR = 3'b111;

    // Decode class membership and per-bit controls
    always_comb begin
        ctl_o.mine      = (word_i[WORD_W-1:OPC_LSB] == OPC_OPR) && word_i[GRP_BIT] && !word_i[0];
        ctl_o.clr       = word_i[7];
        ctl_o.t_sign    = word_i[6];
        ctl_o.t_zero    = word_i[5];
        ctl_o.t_link    = word_i[4];
        ctl_o.sense_inv = word_i[3];
        ctl_o.osr       = word_i[2];
        ctl_o.hlt       = word_i[1];
    end
endmodule

// File: rtl/skp_cond.sv
// Module: skp_cond
// Evaluates the enabled tests on the pre-clear accumulator and link.
// Applies the sense bit to form the skip decision.
// Assumes the two's complement sign is the top accumulator bit.
module skp_cond
    import skp_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  skp_ctl_t          ctl_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              link_i,
    output logic              skip_o
);
    localparam int NTEST = 3;
    logic [NTEST-1:0] en;
    logic [NTEST-1:0] cond;
    logic [NTEST-1:0] hit;
    logic             any_hit;

    // Gather test enables and raw conditions
    always_comb begin
        en   = {ctl_i.t_sign, ctl_i.t_zero, ctl_i.t_link};
        cond = {acc_i[DATA_W-1], (acc_i == '0), link_i};
    end

    // Per-test hit, one gate per test
    for (genvar g = 0; g < NTEST; g++) begin : g_hit
        assign hit[g] = en[g] & cond[g];
    end

    // Combine hits with the selected sense
    always_comb begin
        any_hit = |hit;
        skip_o  = ctl_i.sense_inv ? !any_hit : any_hit;
    end
endmodule

// File: rtl/skp_pc_inc.sv
// Module: skp_pc_inc
// Advances a PC offset by one, wrapping inside its field.
// The field is not touched here.
module skp_pc_inc #(
    parameter int OFF_W = 12
) (
    input  logic [OFF_W-1:0] off_i,
    output logic [OFF_W-1:0] off_o
);
    // Modulo increment, carry out of the offset is dropped
    always_comb off_o = off_i + OFF_W'(1);
endmodule

// File: rtl/skp_opr2_eval.sv
// Module: skp_opr2_eval (top)
// Executes skip-class operate words and registers the results.
// Assumes valid_i qualifies all inputs. Non-class words pass through.
module skp_opr2_eval
    import skp_pkg::*;
#(
    parameter int DATA_W  = 12,
    parameter int FIELD_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [DATA_W-1:0]  instr_i,
    input  logic [DATA_W-1:0]  acc_i,
    input  logic               link_i,
    input  logic [FIELD_W-1:0] pc_field_i,
    input  logic [DATA_W-1:0]  pc_off_i,
    output logic               valid_o,
    output logic               skip_o,
    output logic [FIELD_W-1:0] pc_field_o,
    output logic [DATA_W-1:0]  pc_off_o,
    output logic [DATA_W-1:0]  acc_o,
    output logic               halt_o,
    output logic               err_o,
    output logic               not_mine_o
);
    skp_ctl_t          ctl;
    logic              cond_skip;
    logic [DATA_W-1:0] off_inc;
    logic              act;
    logic              n_skip, n_halt, n_err, n_nm;
    logic [DATA_W-1:0] n_off, n_acc;

    skp_decode #(.WORD_W(DATA_W)) u_dec (
        .word_i (instr_i),
        .ctl_o  (ctl)
    );

    skp_cond #(.DATA_W(DATA_W)) u_cond (
        .ctl_i  (ctl),
        .acc_i  (acc_i),
        .link_i (link_i),
        .skip_o (cond_skip)
    );

    skp_pc_inc #(.OFF_W(DATA_W)) u_inc (
        .off_i (pc_off_i),
        .off_o (off_inc)
    );

    // Next-state effects; an unsupported word or a foreign word has no effect
    always_comb begin
        act    = valid_i && ctl.mine && !ctl.osr;
        n_nm   = valid_i && !ctl.mine;
        n_err  = valid_i && ctl.mine && ctl.osr;
        n_skip = act && cond_skip;
        n_halt = act && ctl.hlt;
        n_off  = n_skip ? off_inc : pc_off_i;
        n_acc  = (act && ctl.clr) ? '0 : acc_i;
    end

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            skip_o     <= 1'b0;
            halt_o     <= 1'b0;
            err_o      <= 1'b0;
            not_mine_o <= 1'b0;
            pc_field_o <= '0;
            pc_off_o   <= '0;
            acc_o      <= '0;
        end else begin
            valid_o    <= valid_i;
            skip_o     <= n_skip;
            halt_o     <= n_halt;
            err_o      <= n_err;
            not_mine_o <= n_nm;
            pc_field_o <= pc_field_i;
            pc_off_o   <= n_off;
            acc_o      <= n_acc;
        end
    end
endmodule

// File: rtl/skp_opr2_eval_chk.sv
// Module: skp_opr2_eval_chk
// Temporal checks on the evaluator's ports, attached by bind.
module skp_opr2_eval_chk #(
    parameter int DATA_W  = 12,
    parameter int FIELD_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               valid_i,
    input logic [DATA_W-1:0]  instr_i,
    input logic [DATA_W-1:0]  acc_i,
    input logic [FIELD_W-1:0] pc_field_i,
    input logic [DATA_W-1:0]  pc_off_i,
    input logic               valid_o,
    input logic               skip_o,
    input logic [FIELD_W-1:0] pc_field_o,
    input logic [DATA_W-1:0]  pc_off_o,
    input logic [DATA_W-1:0]  acc_o,
    input logic               halt_o,
    input logic               err_o,
    input logic               not_mine_o
);
    // Result valid follows the input qualifier by one clock
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // Foreign words leave PC and accumulator untouched
    p_passthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (instr_i[11:8] != 4'hF || instr_i[0])) |=>
        (not_mine_o && !skip_o && pc_off_o == $past(pc_off_i) && acc_o == $past(acc_i)));

    // A skip advances the offset by one; the field never changes
    p_skip_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (pc_field_o == $past(pc_field_i)) &&
        (skip_o ? pc_off_o == DATA_W'($past(pc_off_i) + 1) : pc_off_o == $past(pc_off_i)));

    // An unsupported word has no other effect
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!skip_o && !halt_o && !not_mine_o));

    // Halt only comes from a word in the class
    p_halt_mine_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (!not_mine_o && valid_o));

    // At most one of the classification flags is raised
    p_class_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_o, not_mine_o}));
endmodule

bind skp_opr2_eval skp_opr2_eval_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i), .acc_i(acc_i),
    .pc_field_i(pc_field_i), .pc_off_i(pc_off_i), .valid_o(valid_o), .skip_o(skip_o),
    .pc_field_o(pc_field_o), .pc_off_o(pc_off_o), .acc_o(acc_o), .halt_o(halt_o),
    .err_o(err_o), .not_mine_o(not_mine_o)
);

// File: tb/skp_opr2_eval_test.sv
module skp_opr2_eval_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [11:0] instr_i = '0, acc_i = '0, pc_off_i = '0;
    logic        link_i = 1'b0;
    logic [2:0]  pc_field_i = '0;
    logic        valid_o, skip_o, halt_o, err_o, not_mine_o;
    logic [2:0]  pc_field_o;
    logic [11:0] pc_off_o, acc_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    skp_opr2_eval uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i), .acc_i(acc_i),
        .link_i(link_i), .pc_field_i(pc_field_i), .pc_off_i(pc_off_i), .valid_o(valid_o),
        .skip_o(skip_o), .pc_field_o(pc_field_o), .pc_off_o(pc_off_o), .acc_o(acc_o),
        .halt_o(halt_o), .err_o(err_o), .not_mine_o(not_mine_o)
    );

    // Entry: instr, acc, link, offset, field, expected {skip, halt, err, nm, clr}
    localparam int NV = 26;
    localparam logic [44:0] TBL [NV] = '{
        {12'o7500, 12'o4000, 1'b0, 12'o0100, 3'd0, 5'b10000}, // R2 sign set
        {12'o7500, 12'o3777, 1'b0, 12'o0100, 3'd0, 5'b00000}, // R2 sign clear
        {12'o7440, 12'o0000, 1'b0, 12'o0200, 3'd1, 5'b10000}, // R2 zero
        {12'o7440, 12'o0001, 1'b1, 12'o0200, 3'd1, 5'b00000}, // R2 nonzero
        {12'o7420, 12'o0123, 1'b1, 12'o0300, 3'd2, 5'b10000}, // R2 link set
        {12'o7400, 12'o0000, 1'b1, 12'o0300, 3'd2, 5'b00000}, // R2 no tests
        {12'o7540, 12'o0000, 1'b0, 12'o0400, 3'd3, 5'b10000}, // R2 OR of two
        {12'o7410, 12'o4000, 1'b1, 12'o0500, 3'd4, 5'b10000}, // R3 no tests
        {12'o7510, 12'o4000, 1'b0, 12'o0500, 3'd4, 5'b00000}, // R3 negative
        {12'o7510, 12'o0001, 1'b0, 12'o0500, 3'd4, 5'b10000}, // R3 positive
        {12'o7450, 12'o0000, 1'b0, 12'o0600, 3'd5, 5'b00000}, // R3 zero
        {12'o7450, 12'o0005, 1'b0, 12'o0600, 3'd5, 5'b10000}, // R3 nonzero
        {12'o7430, 12'o0000, 1'b1, 12'o0700, 3'd6, 5'b00000}, // R3 link set
        {12'o7430, 12'o0000, 1'b0, 12'o0700, 3'd6, 5'b10000}, // R3 link clear
        {12'o7570, 12'o0001, 1'b0, 12'o1000, 3'd7, 5'b10000}, // R3 all clear
        {12'o7570, 12'o0001, 1'b1, 12'o1000, 3'd7, 5'b00000}, // R3 one fails
        {12'o7640, 12'o0000, 1'b0, 12'o1100, 3'd0, 5'b10001}, // R4 clr+zero
        {12'o7640, 12'o0007, 1'b0, 12'o1100, 3'd0, 5'b00001}, // R4 clr on nonzero
        {12'o7650, 12'o0007, 1'b0, 12'o1200, 3'd1, 5'b10001}, // R4 clr+nonzero
        {12'o7410, 12'o1234, 1'b0, 12'o7777, 3'd5, 5'b10000}, // R5 wrap
        {12'o7402, 12'o0042, 1'b0, 12'o1300, 3'd2, 5'b01000}, // R6 halt
        {12'o7412, 12'o0042, 1'b0, 12'o1300, 3'd2, 5'b11000}, // R6 halt+skip
        {12'o7644, 12'o0000, 1'b1, 12'o1400, 3'd3, 5'b00100}, // R7 switch-OR
        {12'o7401, 12'o0777, 1'b1, 12'o1500, 3'd4, 5'b00010}, // R1 other group
        {12'o7200, 12'o0777, 1'b0, 12'o1600, 3'd5, 5'b00010}, // R1 bit 8 clear
        {12'o1234, 12'o0055, 1'b0, 12'o1700, 3'd6, 5'b00010}  // R1 other opcode
    };

    task automatic cmp(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0o expected=%0o", req, what, act, exp);
        end
    endtask

    // Drive one word, then sample the registered result one clock later
    task automatic apply(input logic [44:0] e, input string req);
        logic [11:0] ins, acc, off;
        logic lk; logic [2:0] fld; logic sk, hl, er, nm, cl;
        {ins, acc, lk, off, fld, sk, hl, er, nm, cl} = e;
        @(negedge clk);
        valid_i = 1'b1; instr_i = ins; acc_i = acc; link_i = lk;
        pc_off_i = off; pc_field_i = fld;
        @(negedge clk);
        valid_i = 1'b0;
        n_vec++;
        cmp(req, "valid_o R8", int'(valid_o), 1);
        cmp(req, "skip_o", int'(skip_o), int'(sk));
        cmp(req, "halt_o", int'(halt_o), int'(hl));
        cmp(req, "err_o", int'(err_o), int'(er));
        cmp(req, "not_mine_o", int'(not_mine_o), int'(nm));
        cmp(req, "pc_off_o R5", int'(pc_off_o), int'(sk ? 12'(off + 12'd1) : off));
        cmp(req, "pc_field_o R5", int'(pc_field_o), int'(fld));
        cmp(req, "acc_o R4", int'(acc_o), int'(cl ? 12'd0 : acc));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        n_vec++;
        cmp("R8", "reset valid_o", int'(valid_o), 0);
        cmp("R8", "reset flags", int'({skip_o, halt_o, err_o, not_mine_o}), 0);
        cmp("R8", "reset pc_off_o", int'(pc_off_o), 0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) apply(TBL[i], $sformatf("vec%0d", i));
        // R8 idle cycle after a valid word clears all flags
        apply({12'o7410, 12'o0000, 1'b0, 12'o0010, 3'd1, 5'b10000}, "R8 pre-idle");
        @(negedge clk);
        n_vec++;
        cmp("R8", "idle valid_o", int'(valid_o), 0);
        cmp("R8", "idle flags", int'({skip_o, halt_o, err_o, not_mine_o}), 0);
        // R8 synchronous reset mid-run
        @(negedge clk);
        valid_i = 1'b1; instr_i = 12'o7412; acc_i = 12'o0; pc_off_i = 12'o50;
        rst_n = 1'b0;
        @(negedge clk);
        n_vec++;
        cmp("R8", "reset wins valid_o", int'(valid_o), 0);
        cmp("R8", "reset wins halt_o", int'(halt_o), 0);
        valid_i = 1'b0; rst_n = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule